// File: doc/BRIEF.md
# Unaligned Load Merge Unit

This block serves word loads on a 32-bit, byte-addressed, little-endian memory that can only return whole aligned 4-byte words. It supports three load kinds. The first is the ordinary aligned word load. The other two are a left-partial load and a right-partial load. Each partial load merges some byte lanes of one aligned memory word into the current register value, and leaves the other lanes of the register as they were.

Issuing a left-partial load at address a+3 and a right-partial load at address a, in either order, leaves the four bytes that start at the unaligned address a in the register. Neither partial load ever reads outside the aligned word that contains its own address.

The block holds a small read-only memory model with computed contents and a single destination register, so that load sequences can be run end to end. One operation is accepted each clock. Its result appears on the register output one edge later.

Top module: `unaligned_load_merge`

## Requirements
- R1: While reset is low, and on the first sample after it rises, reg_value equals RESET_VALUE (default 0) and misalign is 0.
- R2: The memory byte at byte address b holds (37*b + 5) mod 256. The aligned word with index w carries byte 4w+j in bits [8j+7:8j], for j from 0 to 3.
- R3: An operation with op = 2'b01 and addr[1:0] = 0 loads the whole aligned word into reg_value after the next rising edge and clears misalign.
- R4: An operation with op = 2'b01 and addr[1:0] nonzero leaves reg_value unchanged and sets misalign for the cycle after that edge.
- R5: With op = 2'b10 and k = addr[1:0], bytes k..0 of the aligned word are written into register bytes 3..3-k. The 3-k lower register bytes are kept.
- R6: With op = 2'b11 and k = addr[1:0], bytes 3..k of the aligned word are written into register bytes 3-k..0. The k upper register bytes are kept.
- R7: Both partial loads read only the aligned word that holds their address. Example: the register holds the word at address 0, a left load is done at address 6, then a right load at address 3. The register then holds bytes 6,5,4,3, with byte 6 as the most significant byte.
- R8: A left load at a+3 and a right load at a, in either order, leave {byte(a+3), byte(a+2), byte(a+1), byte(a)} in the register.
- R9: With op = 2'b00 the register holds its value and misalign reads 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 2 | 00 idle, 01 word load, 10 left-partial, 11 right-partial |
| addr | input | ADDR_W (6) | Effective byte address |
| reg_value | output | 32 | Destination register contents |
| misalign | output | 1 | Set for one cycle after a misaligned word load |

## Verification
The bench tries every byte offset of both partial loads. A design that counts lanes from the wrong end, or that is off by one in its shift, puts bytes in the wrong register lanes, or clobbers lanes it should keep at offset 0 or 3. It rebuilds unaligned words at addresses of every alignment, in both orders. A design that reads the neighbouring aligned word, or that merges into the wrong half of the register, returns a word that does not match the unaligned bytes. It also issues misaligned word loads on a register that already holds data. A design that writes anyway, or that leaves the flag stuck, shows a changed register or a flag that stays high after an idle cycle.

// File: rtl/ulm_pkg.sv
package ulm_pkg;

   typedef enum logic [1:0] {
      ULM_IDLE  = 2'b00,
      ULM_WORD  = 2'b01,
      ULM_LEFT  = 2'b10,
      ULM_RIGHT = 2'b11
   } ulm_op_e;

   localparam int unsigned ULM_LANES  = 4;
   localparam int unsigned ULM_WORD_W = 8 * ULM_LANES;

   typedef struct packed {
      logic                  wr;
      logic                  misalign;
      logic [ULM_WORD_W-1:0] value;
   } ulm_result_t;

endpackage

// File: rtl/ulm_word_rom.sv
module ulm_word_rom #(
   parameter int unsigned WORDS    = 16,
   parameter int unsigned BYTE_MUL = 37,
   parameter int unsigned BYTE_ADD = 5,
   parameter int unsigned IDX_W    = $clog2(WORDS)
) (
   input  logic [IDX_W-1:0]                idx,
   output logic [ulm_pkg::ULM_WORD_W-1:0]  word
);
   import ulm_pkg::*;

   if (WORDS < 2 || (WORDS & (WORDS - 1)) != 0) begin : g_bad_words
      $error("ulm_word_rom: WORDS must be a power of two, at least 2");
   end

   logic [ULM_WORD_W-1:0] rom [WORDS];

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      for (genvar j = 0; j < ULM_LANES; j++) begin : g_byte
         localparam int unsigned BV = (BYTE_MUL * (ULM_LANES * w + j) + BYTE_ADD) % 256;
         localparam logic [7:0]  BB = BV[7:0];
         assign rom[w][8*j +: 8] = BB;
      end
   end

   assign word = rom[idx];

endmodule

// File: rtl/ulm_lane_merge.sv
module ulm_lane_merge (
   input  ulm_pkg::ulm_op_e                op,
   input  logic [1:0]                      k,
   input  logic [ulm_pkg::ULM_WORD_W-1:0]  mem_word,
   input  logic [ulm_pkg::ULM_WORD_W-1:0]  old_value,
   output ulm_pkg::ulm_result_t            res
);
   import ulm_pkg::*;

   logic [ULM_WORD_W-1:0] merged;
   logic                  bad_word;

   assign bad_word = (op == ULM_WORD) && (k != 2'd0);

   for (genvar i = 0; i < ULM_LANES; i++) begin : g_lane
      logic       left_hit;
      logic       right_hit;
      logic [1:0] left_src;
      logic [1:0] right_src;
      logic [7:0] old_b;
      logic [7:0] lane_b;

      // left: lane i takes word byte i+k-3 when i >= 3-k
      assign left_hit  = ({1'b0, k} + 3'(i)) >= 3'd3;
      assign left_src  = k + 2'(i) + 2'd1;
      // right: lane i takes word byte i+k when i+k <= 3
      assign right_hit = ({1'b0, k} + 3'(i)) <= 3'd3;
      assign right_src = k + 2'(i);
      assign old_b     = old_value[8*i +: 8];

      always_comb begin
         case (op)
            ULM_WORD:  lane_b = bad_word  ? old_b : mem_word[8*i +: 8];
            ULM_LEFT:  lane_b = left_hit  ? mem_word[8*left_src +: 8]  : old_b;
            ULM_RIGHT: lane_b = right_hit ? mem_word[8*right_src +: 8] : old_b;
            default:   lane_b = old_b;
         endcase
      end

      assign merged[8*i +: 8] = lane_b;
   end

   assign res.value    = merged;
   assign res.misalign = bad_word;
   assign res.wr       = (op != ULM_IDLE) && !bad_word;

endmodule

// File: rtl/ulm_dest_reg.sv
module ulm_dest_reg #(
   parameter logic [ulm_pkg::ULM_WORD_W-1:0] RESET_VALUE = '0
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            load_en,
   input  logic [ulm_pkg::ULM_WORD_W-1:0]  d,
   input  logic                            flag_d,
   output logic [ulm_pkg::ULM_WORD_W-1:0]  q,
   output logic                            flag_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q      <= RESET_VALUE;
         flag_q <= 1'b0;
      end else begin
         if (load_en) q <= d;
         flag_q <= flag_d;
      end
   end
endmodule

// File: rtl/unaligned_load_merge.sv
module unaligned_load_merge #(
   parameter int unsigned MEM_WORDS   = 16,
   parameter int unsigned BYTE_MUL    = 37,
   parameter int unsigned BYTE_ADD    = 5,
   parameter int unsigned ADDR_W      = $clog2(MEM_WORDS) + 2,
   parameter logic [31:0] RESET_VALUE = 32'h0000_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        op,
   input  logic [ADDR_W-1:0] addr,
   output logic [31:0]       reg_value,
   output logic              misalign
);
   import ulm_pkg::*;

   localparam int unsigned IDX_W = ADDR_W - 2;

   if (ADDR_W != $clog2(MEM_WORDS) + 2) begin : g_bad_addr
      $error("unaligned_load_merge: ADDR_W must cover MEM_WORDS words exactly");
   end
   if (ULM_WORD_W != 32) begin : g_bad_width
      $error("unaligned_load_merge: word width must be 32 bits");
   end

   ulm_op_e     op_e;
   logic [31:0] mem_word;
   ulm_result_t res;

   assign op_e = ulm_op_e'(op);

   ulm_word_rom #(
      .WORDS    (MEM_WORDS),
      .BYTE_MUL (BYTE_MUL),
      .BYTE_ADD (BYTE_ADD),
      .IDX_W    (IDX_W)
   ) u_rom (
      .idx  (addr[ADDR_W-1:2]),
      .word (mem_word)
   );

   ulm_lane_merge u_merge (
      .op        (op_e),
      .k         (addr[1:0]),
      .mem_word  (mem_word),
      .old_value (reg_value),
      .res       (res)
   );

   ulm_dest_reg #(
      .RESET_VALUE (RESET_VALUE)
   ) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_en (res.wr),
      .d       (res.value),
      .flag_d  (res.misalign),
      .q       (reg_value),
      .flag_q  (misalign)
   );

   assert_aligned_clears_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (op == 2'b01 && addr[1:0] == 2'd0) |=> !misalign);

   assert_misaligned_holds_reg_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (op == 2'b01 && addr[1:0] != 2'd0) |=> (misalign && $stable(reg_value)));

   assert_flag_only_from_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
      misalign |-> ($past(op) == 2'b01));

   assert_left_keeps_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (op == 2'b10 && addr[1:0] == 2'd0) |=> (reg_value[23:0] == $past(reg_value[23:0])));

   assert_right_keeps_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (op == 2'b11 && addr[1:0] == 2'd3) |=> (reg_value[31:8] == $past(reg_value[31:8])));

   assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (op == 2'b00) |=> ($stable(reg_value) && !misalign));

endmodule

// File: tb/unaligned_load_merge_bench.sv
`timescale 1ns/1ps
module unaligned_load_merge_bench;

   localparam int ADDR_W = 6;
   localparam int NVEC   = 16;
   localparam logic [7:0] VEC [NVEC] = '{
      {2'd1, 6'd0},  {2'd2, 6'd13}, {2'd3, 6'd13}, {2'd1, 6'd21},
      {2'd0, 6'd0},  {2'd3, 6'd34}, {2'd2, 6'd47}, {2'd1, 6'd40},
      {2'd2, 6'd52}, {2'd1, 6'd58}, {2'd3, 6'd63}, {2'd2, 6'd60},
      {2'd1, 6'd12}, {2'd3, 6'd1},  {2'd2, 6'd30}, {2'd0, 6'd9}
   };

   logic              clk = 1'b0;
   logic              rst_n;
   logic [1:0]        op;
   logic [ADDR_W-1:0] addr;
   logic [31:0]       reg_value;
   logic              misalign;

   int unsigned n_checks = 0;
   int unsigned n_fail   = 0;
   logic [31:0] exp_reg;
   logic        exp_mis;
   bit          finished = 1'b0;

   always #2.5 clk = ~clk;

   unaligned_load_merge u_unaligned_load_merge (
      .clk       (clk),
      .rst_n     (rst_n),
      .op        (op),
      .addr      (addr),
      .reg_value (reg_value),
      .misalign  (misalign)
   );

   function automatic logic [7:0] mem_byte(input int b);
      int v;
      v = (37 * b + 5) % 256;
      return v[7:0];
   endfunction

   function automatic logic [31:0] mem_word_at(input int a);
      int base;
      base = a - (a % 4);
      return {mem_byte(base + 3), mem_byte(base + 2), mem_byte(base + 1), mem_byte(base)};
   endfunction

   task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] expv);
      n_checks++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, expv);
      end
   endtask

   task automatic check1(input string tag, input logic act, input logic expv);
      n_checks++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s: actual %0b expected %0b", tag, act, expv);
      end
   endtask

   // Drives one operation, waits for it to take effect and updates the model.
   task automatic issue(input logic [1:0] o, input int a);
      logic [31:0] w;
      int k;
      op   = o;
      addr = ADDR_W'(a);
      @(negedge clk);
      w = mem_word_at(a);
      k = a % 4;
      exp_mis = 1'b0;
      case (o)
         2'd1: if (k == 0) exp_reg = w; else exp_mis = 1'b1;
         2'd2: exp_reg = (w << (8 * (3 - k))) | (exp_reg & (32'hFFFF_FFFF >> (8 * (k + 1))));
         2'd3: exp_reg = (w >> (8 * k)) | (exp_reg & ~(32'hFFFF_FFFF >> (8 * k)));
         default: ;
      endcase
      op = 2'd0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      op    = 2'd0;
      addr  = '0;
      repeat (3) @(negedge clk);
      check32("R1 reset reg", reg_value, 32'h0);
      check1("R1 reset flag", misalign, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check32("R1 after release", reg_value, 32'h0);
      exp_reg = 32'h0;
      exp_mis = 1'b0;

      // Table walk
      for (int v = 0; v < NVEC; v++) begin
         issue(VEC[v][7:6], int'(VEC[v][5:0]));
         check32("R3 R5 R6 R9 table reg", reg_value, exp_reg);
         check1("R4 R9 table flag", misalign, exp_mis);
      end

      // R2/R3: every aligned word
      for (int w = 0; w < 16; w++) begin
         issue(2'd1, 4 * w);
         check32("R2 R3 aligned word", reg_value,
                 {mem_byte(4*w+3), mem_byte(4*w+2), mem_byte(4*w+1), mem_byte(4*w)});
         check1("R3 flag clear", misalign, 1'b0);
      end

      // R4: misaligned word loads keep the register
      for (int k = 1; k < 4; k++) begin
         issue(2'd1, 20);
         issue(2'd1, 32 + k);
         check32("R4 reg kept", reg_value, mem_word_at(20));
         check1("R4 flag set", misalign, 1'b1);
         issue(2'd0, 0);
         check1("R9 flag drops", misalign, 1'b0);
         check32("R9 idle hold", reg_value, mem_word_at(20));
      end

      // R5 / R6: every offset of both partial loads
      for (int k = 0; k < 4; k++) begin
         issue(2'd1, 0);
         issue(2'd2, 8 + k);
         check32("R5 left offset", reg_value, exp_reg);
         issue(2'd1, 0);
         issue(2'd3, 8 + k);
         check32("R6 right offset", reg_value, exp_reg);
      end

      // R7: worked example
      issue(2'd1, 0);
      issue(2'd2, 6);
      check32("R7 left at 6", reg_value, {mem_byte(6), mem_byte(5), mem_byte(4), mem_byte(3)} & 32'hFFFF_FF00
              | {24'h0, mem_byte(0)});
      issue(2'd3, 3);
      check32("R7 right at 3", reg_value, {mem_byte(6), mem_byte(5), mem_byte(4), mem_byte(3)});

      // R8: reconstruction of unaligned words, both orders
      for (int a = 0; a <= 60; a += 5) begin
         issue(2'd1, (4 * a + 8) % 64);
         issue(2'd2, a + 3);
         issue(2'd3, a);
         check32("R8 left then right", reg_value,
                 {mem_byte(a+3), mem_byte(a+2), mem_byte(a+1), mem_byte(a)});
         issue(2'd1, 44);
         issue(2'd3, a);
         issue(2'd2, a + 3);
         check32("R8 right then left", reg_value,
                 {mem_byte(a+3), mem_byte(a+2), mem_byte(a+1), mem_byte(a)});
      end

      // R1: reset in the middle of a run
      issue(2'd1, 28);
      issue(2'd1, 29);
      rst_n = 1'b0;
      @(negedge clk);
      check32("R1 mid-run reset reg", reg_value, 32'h0);
      check1("R1 mid-run reset flag", misalign, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule